// File: doc/BRIEF.md
# Masked Local-Bus Interrupt Encoder

This block gathers sixteen level-sensitive interrupt request lines into a source register, qualifies them with an enable mask held in a register, and drives one combined interrupt request toward the processor. Each source bit copies its input line on every clock. There is no edge capture and no acknowledge. A source clears as soon as its line drops.

Software reaches the block through a small 16-bit register port. One location returns an encoded value for the pending enabled source with the lowest index, ready for use as a jump-table offset: (index + 1) times 4, or zero when nothing is pending. A second location reads and writes the enable mask. After reset the mask enables only source 4, so a device on that line can interrupt before software has set anything up.

Top module: `irq_enc_top`

## Requirements
- R1: Each source bit takes the level of its input line at every rising clock edge. It is set while the line is high and cleared while the line is low.
- R2: `irq_out` is a register. After each edge it is high exactly when the source register ANDed with the mask register is non-zero, so it follows an input or mask change one clock later.
- R3: A full-width read at byte offset 0x000 returns (i + 1) << 2, where i is the lowest-numbered source that is both set and enabled. It returns 0 when no enabled source is set. Source 0 gives 4 and source 15 gives 64.
- R4: A full-width read at byte offset 0x002 returns the enable mask, where bit n enables source n. A full-width write there replaces the mask, and `irq_out` reflects the new mask after the same edge.
- R5: A synchronous active-high reset sets the mask to 0x0010, clears the source register, and drives `irq_out` and `acc_rdata` to 0.
- R6: Only 16-bit accesses are accepted, meaning `acc_be` equals 2'b11. A write with any other `acc_be` leaves the mask unchanged, and a read with any other `acc_be` returns 0.
- R7: Reads of offsets other than 0x000 and 0x002 return 0. Writes to those offsets change nothing.
- R8: Read data is registered. `acc_rdata` carries the result in the cycle after the request and is 0 after any cycle without a read. A read in the same cycle as a mask write returns the mask value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 16 | Level-sensitive interrupt request lines |
| acc_rd | input | 1 | Read request |
| acc_wr | input | 1 | Write request |
| acc_addr | input | 12 | Byte offset of the access |
| acc_be | input | 2 | Byte enables, both set for a valid access |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Combined masked interrupt request |

## Verification
A mask write can land on the same edge as a change on the request lines. It can also coincide with a read of either register. The bench drives each of these pairs in a single cycle. One case writes a new mask while a line rises that only the new mask enables. Another reads the mask during a write to it. A cycle-level reference model predicts `irq_out` and `acc_rdata` from the pre-edge state, so a design that lets the write overtake the read, or that computes the request from the stale mask, differs from the model within one clock.

// File: rtl/irq_enc_pkg.sv
package irq_enc_pkg;
  localparam int unsigned NUM_SRC   = 16;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned ADDR_W    = 12;
  localparam int unsigned BE_W      = DATA_W / 8;
  localparam logic [ADDR_W-1:0] OFS_CODE = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_MASK = 12'h002;
  localparam logic [DATA_W-1:0] MASK_RST = 16'h0010;

  typedef enum logic [1:0] {SEL_NONE, SEL_CODE, SEL_MASK} reg_sel_e;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  output logic [N-1:0] src_q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) src_q[g] <= 1'b0;
      else     src_q[g] <= lines[g];
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q
);
  always_comb mask_d = we ? wdata : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= RST_VAL;
    else     mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 16,
  parameter int unsigned W = 16
) (
  input  logic [N-1:0] pend,
  output logic [W-1:0] code
);
  logic [N-1:0] below;
  logic [N-1:0] first;
  logic [W-1:0] term [N];

  for (genvar g = 0; g < N; g++) begin : g_chain
    if (g == 0) begin : g_lo
      assign below[g] = 1'b0;
    end else begin : g_hi
      assign below[g] = below[g-1] | pend[g-1];
    end
    localparam logic [W-1:0] VAL = W'((g + 1) * 4);
    assign first[g] = pend[g] & ~below[g];
    assign term[g]  = first[g] ? VAL : '0;
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) code = code | term[i];
  end
endmodule

// File: rtl/irq_enc_top.sv
module irq_enc_top
  import irq_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic              acc_rd,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [BE_W-1:0]   acc_be,
  input  logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              irq_out
);
  logic              full_acc;
  reg_sel_e          sel;
  logic              mask_we;
  logic [NUM_SRC-1:0] src_q;
  logic [DATA_W-1:0] mask_q, mask_d;
  logic [DATA_W-1:0] code;
  logic [DATA_W-1:0] rd_mux;

  assign full_acc = &acc_be;

  always_comb begin
    unique case (acc_addr)
      OFS_CODE: sel = SEL_CODE;
      OFS_MASK: sel = SEL_MASK;
      default:  sel = SEL_NONE;
    endcase
  end

  assign mask_we = acc_wr && full_acc && (sel == SEL_MASK);

  irq_src_latch #(.N(NUM_SRC)) i_src (
    .clk(clk), .rst(rst), .lines(irq_lines), .src_q(src_q)
  );

  irq_mask_reg #(.W(DATA_W), .RST_VAL(MASK_RST)) i_mask (
    .clk(clk), .rst(rst), .we(mask_we), .wdata(acc_wdata),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  irq_prio_enc #(.N(NUM_SRC), .W(DATA_W)) i_enc (
    .pend(src_q & mask_q[NUM_SRC-1:0]), .code(code)
  );

  always_comb begin
    rd_mux = '0;
    if (acc_rd && full_acc) begin
      case (sel)
        SEL_CODE: rd_mux = code;
        SEL_MASK: rd_mux = mask_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      acc_rdata <= rd_mux;
      irq_out   <= |(irq_lines & mask_d[NUM_SRC-1:0]);
    end
  end
endmodule

// File: rtl/irq_enc_checks.sv
module irq_enc_checks
  import irq_enc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [NUM_SRC-1:0] irq_lines,
  input logic              acc_rd,
  input logic              acc_wr,
  input logic [BE_W-1:0]   acc_be,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              irq_out,
  input logic [NUM_SRC-1:0] src_q,
  input logic [DATA_W-1:0] mask_q
);
  a_r1_src_tracks: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> src_q == $past(irq_lines));

  a_r2_irq_matches: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(src_q & mask_q[NUM_SRC-1:0]));

  a_r5_reset_state: assert property (@(posedge clk)
    rst |=> (mask_q == MASK_RST && src_q == '0 && !irq_out && acc_rdata == '0));

  a_r6_partial_write: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && !(&acc_be)) |=> $stable(mask_q));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> acc_rdata == '0);
endmodule

bind irq_enc_top irq_enc_checks i_checks (
  .clk(clk), .rst(rst), .irq_lines(irq_lines), .acc_rd(acc_rd),
  .acc_wr(acc_wr), .acc_be(acc_be), .acc_rdata(acc_rdata),
  .irq_out(irq_out), .src_q(src_q), .mask_q(mask_q)
);

// File: tb/test_irq_enc_top.sv
`timescale 1ns/1ps
module test_irq_enc_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] irq_lines;
  logic        acc_rd, acc_wr;
  logic [11:0] acc_addr;
  logic [1:0]  acc_be;
  logic [15:0] acc_wdata;
  logic [15:0] acc_rdata;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R5";

  int m_src, m_mask, m_rd;
  bit m_irq;

  always #2 clk = ~clk;

  irq_enc_top i_irq_enc_top (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .acc_rd(acc_rd),
    .acc_wr(acc_wr), .acc_addr(acc_addr), .acc_be(acc_be),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq_out(irq_out)
  );

  function automatic int lowest_code(int pend);
    int idx = 0;
    if (pend == 0) return 0;
    while (((pend >> idx) & 1) == 0) idx++;
    return (idx + 1) * 4;
  endfunction

  task automatic tick();
    int nxt_rd;
    @(posedge clk);
    if (rst) begin
      m_src = 0; m_mask = 'h10; m_irq = 0; m_rd = 0;
    end else begin
      nxt_rd = 0;
      if (acc_rd && acc_be == 2'b11) begin
        if (acc_addr == 12'h000)      nxt_rd = lowest_code(m_src & m_mask);
        else if (acc_addr == 12'h002) nxt_rd = m_mask;
      end
      if (acc_wr && acc_be == 2'b11 && acc_addr == 12'h002) m_mask = acc_wdata;
      m_src = irq_lines;
      m_irq = (m_src & m_mask) != 0;
      m_rd  = nxt_rd;
    end
    #1;
    checks++;
    if (irq_out !== m_irq) begin
      errors++;
      $display("FAIL %s irq_out actual %b expected %b", cur_req, irq_out, m_irq);
    end
    checks++;
    if (acc_rdata !== 16'(m_rd)) begin
      errors++;
      $display("FAIL %s acc_rdata actual %h expected %h", cur_req, acc_rdata, 16'(m_rd));
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) begin
      acc_rd = 0; acc_wr = 0;
      tick();
    end
  endtask

  task automatic acc(bit rd, bit wr, logic [11:0] a, logic [1:0] be, logic [15:0] d);
    acc_rd = rd; acc_wr = wr; acc_addr = a; acc_be = be; acc_wdata = d;
    tick();
    acc_rd = 0; acc_wr = 0;
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; irq_lines = 0; acc_rd = 0; acc_wr = 0;
    acc_addr = 0; acc_be = 2'b11; acc_wdata = 0;
    cur_req = "R5";
    tick(); tick();
    rst = 0;
    acc(1, 0, 12'h002, 2'b11, 0);
    idle(1);
    cur_req = "R1";
    irq_lines = 16'h0010; idle(1);
    acc(1, 0, 12'h000, 2'b11, 0);
    cur_req = "R3";
    irq_lines = 16'h0011; idle(1);
    acc(1, 0, 12'h000, 2'b11, 0);
    cur_req = "R4";
    acc(0, 1, 12'h002, 2'b11, 16'hFFFF);
    acc(1, 0, 12'h002, 2'b11, 0);
    cur_req = "R3";
    acc(1, 0, 12'h000, 2'b11, 0);
    irq_lines = 16'h8000; idle(1);
    acc(1, 0, 12'h000, 2'b11, 0);
    irq_lines = 16'h0000; idle(1);
    acc(1, 0, 12'h000, 2'b11, 0);
    cur_req = "R2";
    irq_lines = 16'h0400; idle(2);
    acc(0, 1, 12'h002, 2'b11, 16'h0000);
    irq_lines = 16'h0000; idle(1);
    cur_req = "R6";
    acc(0, 1, 12'h002, 2'b01, 16'h00F0);
    acc(0, 1, 12'h002, 2'b10, 16'h0F00);
    acc(1, 0, 12'h002, 2'b11, 0);
    acc(1, 0, 12'h002, 2'b10, 0);
    cur_req = "R7";
    acc(0, 1, 12'h004, 2'b11, 16'h1234);
    acc(1, 0, 12'h004, 2'b11, 0);
    acc(1, 0, 12'h002, 2'b11, 0);
    acc(1, 0, 12'h006, 2'b11, 0);
    cur_req = "R8";
    acc(1, 1, 12'h002, 2'b11, 16'h0C00);
    acc(1, 0, 12'h002, 2'b11, 0);
    cur_req = "R2";
    irq_lines = 16'h0003;
    acc(0, 1, 12'h002, 2'b11, 16'h0002);
    acc(1, 0, 12'h000, 2'b11, 0);
    irq_lines = 16'h0000;
    acc(0, 1, 12'h002, 2'b11, 16'hFFFF);
    idle(2);
    cur_req = "R5";
    rst = 1; irq_lines = 16'hFFFF; tick();
    rst = 0; irq_lines = 0;
    acc(1, 0, 12'h002, 2'b11, 0);
    idle(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule